// File: doc/BRIEF.md
# Bootstrap Capacitor Refresh Controller

This block sits beside the gate-drive logic of a synchronous buck power stage. Two digital flags come from analog comparators: one says the bootstrap capacitor has drooped below its low threshold, the other says it has charged back above its recovery threshold. When the stage is enabled, the supply is ready and the capacitor has drooped, the block takes control of the low-side gate. While it holds control, the normal PWM command is disregarded. It then fires narrow low-side pulses at a long fixed spacing, and each pulse recharges the capacitor a little. It gives control back once the recovery flag is seen.

The pulse width and the pulse spacing are parameters counted in clock cycles. The defaults at a 200 MHz clock give 150 ns pulses every 10 µs. The downstream gate mux uses `override_active` to choose the refresh gate over the PWM-derived gate. Dropping either permission input ends refresh at once, without waiting for a clock edge.

Top module: `boot_refresh_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after reset is released with `cap_low` low, `override_active` and `refresh_gl` are both 0.
- R2: Refresh starts only at a clock edge where `stage_en`, `supply_ok` and `cap_low` are all 1 and no refresh is running. In the cycle that follows that edge, `override_active` and `refresh_gl` are both 1.
- R3: Once started, `override_active` stays 1 through every pulse and every gap until refresh exits or is aborted, whatever `cap_low` does.
- R4: Each refresh pulse holds `refresh_gl` at 1 for exactly PULSE_CYC consecutive cycles, unless an abort cuts it short.
- R5: Pulses start every PERIOD_CYC cycles. In cycle j after the start edge, `refresh_gl` is 1 exactly when (j mod PERIOD_CYC) < PULSE_CYC.
- R6: Refresh exits at the first clock edge at which `cap_recovered` is 1 and the current pulse has finished its last cycle. From the following cycle, both outputs are 0.
- R7: A pulse already under way always runs to its full width, even when `cap_recovered` rises during that pulse.
- R8: When `stage_en` falls, both outputs go to 0 in the same cycle. The refresh state is also cleared, so re-enabling with `cap_low` at 0 leaves `override_active` at 0.
- R9: When `supply_ok` falls, both outputs go to 0 in the same cycle and the refresh state is cleared, in the same way as R8.
- R10: While `stage_en` or `supply_ok` is 0, `cap_low` has no effect. Restoring both permissions later with `cap_low` at 0 leaves `override_active` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stage_en | input | 1 | Power stage enable |
| supply_ok | input | 1 | Driver supply ready |
| cap_low | input | 1 | Bootstrap voltage below the low threshold |
| cap_recovered | input | 1 | Bootstrap voltage above the recovery threshold |
| override_active | output | 1 | Refresh holds the low-side gate; the PWM command is disregarded |
| refresh_gl | output | 1 | Low-side gate request from the refresh engine |

## Verification
The bench builds the block with PULSE_CYC = 3 and PERIOD_CYC = 8. With these values a full refresh cycle lasts only a few dozen clocks.

The recovery flag is swept over every arrival cycle in two whole periods. This covers arrival in each pulse slot, at the last pulse cycle and in each gap slot, so every exit point of R6 and R7 is reached.

Aborts are swept over every cycle position of one period, once for each permission input. The bench computes the expected gate pattern and exit cycle arithmetically from the cycle index.

// File: rtl/bref_pkg.sv
package bref_pkg;
   typedef enum logic {
      PH_PULSE = 1'b0,
      PH_GAP   = 1'b1
   } phase_t;
endpackage

// File: rtl/bref_timer.sv
module bref_timer
   import bref_pkg::*;
#(
   parameter int PULSE_CYC  = 30,
   parameter int PERIOD_CYC = 2000
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clear,
   input  logic   run,
   output phase_t phase,
   output logic   pulse_done
);
   localparam int CNT_W = $clog2(PERIOD_CYC);
   localparam logic [CNT_W-1:0] LAST_SLOT  = CNT_W'(PERIOD_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_END  = CNT_W'(PULSE_CYC);

   logic [CNT_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (clear) begin
         slot_q <= '0;
      end else if (run) begin
         slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end
   end

   always_comb begin
      phase      = (slot_q < PULSE_END) ? PH_PULSE : PH_GAP;
      pulse_done = (slot_q >= PULSE_LAST);
   end

   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run && !clear |=> slot_q <= LAST_SLOT);  // R5
endmodule

// File: rtl/bref_ctrl.sv
module bref_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic allowed,
   input  logic cap_low,
   input  logic cap_recovered,
   input  logic pulse_done,
   output logic active,
   output logic timer_clear
);
   logic start;
   logic leave;

   always_comb begin
      start       = !active && allowed && cap_low;
      leave       = active && cap_recovered && pulse_done;
      timer_clear = !allowed || start || leave || !active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
      end else if (!allowed) begin
         active <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
      end else if (leave) begin
         active <= 1'b0;
      end
   end

   AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(allowed && cap_low));  // R2
   AST_EXIT_RECOVERED: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(active) && $past(allowed)) |-> $past(cap_recovered));  // R6
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !allowed |=> !active);  // R8
endmodule

// File: rtl/boot_refresh_ctrl.sv
module boot_refresh_ctrl
   import bref_pkg::*;
#(
   parameter int PULSE_CYC  = 30,
   parameter int PERIOD_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stage_en,
   input  logic supply_ok,
   input  logic cap_low,
   input  logic cap_recovered,
   output logic override_active,
   output logic refresh_gl
);
   localparam int CNT_W = $clog2(PERIOD_CYC);
   localparam logic [CNT_W:0] LEN_SAT    = (CNT_W+1)'(PERIOD_CYC + 1);
   localparam logic [CNT_W:0] PULSE_LEN  = (CNT_W+1)'(PULSE_CYC);
   localparam logic [CNT_W:0] PERIOD_LEN = (CNT_W+1)'(PERIOD_CYC);

   initial begin
      assert (PULSE_CYC >= 1) else $error("PULSE_CYC must be at least 1");
      assert (PERIOD_CYC >= 2) else $error("PERIOD_CYC must be at least 2");
      assert (PERIOD_CYC > PULSE_CYC) else $error("PERIOD_CYC must exceed PULSE_CYC");
   end

   logic   allowed;
   logic   active;
   logic   timer_clear;
   logic   pulse_done;
   phase_t phase;

   assign allowed = stage_en && supply_ok;

   bref_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .allowed       (allowed),
      .cap_low       (cap_low),
      .cap_recovered (cap_recovered),
      .pulse_done    (pulse_done),
      .active        (active),
      .timer_clear   (timer_clear)
   );

   bref_timer #(
      .PULSE_CYC  (PULSE_CYC),
      .PERIOD_CYC (PERIOD_CYC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (timer_clear),
      .run        (active),
      .phase      (phase),
      .pulse_done (pulse_done)
   );

   assign override_active = active && allowed;
   assign refresh_gl      = override_active && (phase == PH_PULSE);

   // Width and spacing monitors for the gate output
   logic           gl_d;
   logic           ov_d;
   logic [CNT_W:0] hi_len;
   logic [CNT_W:0] since_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gl_d       <= 1'b0;
         ov_d       <= 1'b0;
         hi_len     <= '0;
         since_rise <= LEN_SAT;
      end else begin
         gl_d <= refresh_gl;
         ov_d <= override_active;
         if (!refresh_gl) hi_len <= '0;
         else if (hi_len != LEN_SAT) hi_len <= hi_len + 1'b1;
         if (refresh_gl && !gl_d) since_rise <= (CNT_W+1)'(1);
         else if (since_rise != LEN_SAT) since_rise <= since_rise + 1'b1;
      end
   end

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (gl_d && !refresh_gl && allowed) |-> hi_len == PULSE_LEN);  // R4
   AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_gl && !gl_d && ov_d) |-> since_rise == PERIOD_LEN);  // R5
endmodule

// File: tb/boot_refresh_ctrl_tb.sv
`timescale 1ns/1ps
module boot_refresh_ctrl_tb;
   localparam int P   = 3;
   localparam int PER = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stage_en = 1'b0;
   logic supply_ok = 1'b0;
   logic cap_low = 1'b0;
   logic cap_recovered = 1'b0;
   logic override_active;
   logic refresh_gl;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   boot_refresh_ctrl #(.PULSE_CYC(P), .PERIOD_CYC(PER)) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .stage_en        (stage_en),
      .supply_ok       (supply_ok),
      .cap_low         (cap_low),
      .cap_recovered   (cap_recovered),
      .override_active (override_active),
      .refresh_gl      (refresh_gl)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exit_cycle(input int r);
      for (int j = r; j < r + 2 * PER; j++)
         if ((j % PER) >= P - 1) return j;
      return -1;
   endfunction

   // Ends at cycle 0 after the start edge, with cap_low already released
   task automatic start_refresh();
      @(negedge clk);
      stage_en = 1'b1; supply_ok = 1'b1; cap_low = 1'b1; cap_recovered = 1'b0;
      #1 chk("R2 no override before edge", int'(override_active), 0);
      @(negedge clk);
      chk("R2 override after start edge", int'(override_active), 1);
      chk("R2 gate after start edge", int'(refresh_gl), 1);
      cap_low = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset
      repeat (3) @(negedge clk);
      chk("R1 override in reset", int'(override_active), 0);
      chk("R1 gate in reset", int'(refresh_gl), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 override after reset", int'(override_active), 0);
      chk("R1 gate after reset", int'(refresh_gl), 0);

      // R10 cap_low ignored without permission
      stage_en = 1'b0; supply_ok = 1'b1; cap_low = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 gate while disabled", int'(refresh_gl), 0);
      supply_ok = 1'b0; stage_en = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 gate while supply low", int'(refresh_gl), 0);
      cap_low = 1'b0; supply_ok = 1'b1;
      #1 chk("R10 no override after restore", int'(override_active), 0);
      repeat (2) @(negedge clk);
      chk("R10 still idle", int'(override_active), 0);

      // R3 R5 R6 R7 sweep of recovery arrival cycle
      for (int r = 0; r < 2 * PER; r++) begin
         int e;
         e = exit_cycle(r);
         start_refresh();
         cap_recovered = (r == 0);
         for (int j = 1; j <= e + PER; j++) begin
            @(negedge clk);
            chk($sformatf("R3 R6 override r=%0d j=%0d", r, j),
                int'(override_active), (j <= e) ? 1 : 0);
            chk($sformatf("R5 R7 gate r=%0d j=%0d", r, j),
                int'(refresh_gl), ((j <= e) && ((j % PER) < P)) ? 1 : 0);
            cap_recovered = (j >= r);
         end
         cap_recovered = 1'b0;
      end

      // R8 (stage_en) and R9 (supply_ok) abort at every slot
      for (int which = 0; which < 2; which++) begin
         for (int a = 0; a < PER; a++) begin
            string tag;
            tag = (which == 0) ? "R8" : "R9";
            start_refresh();
            for (int j = 1; j <= a; j++) begin
               @(negedge clk);
               chk($sformatf("R4 gate before abort a=%0d j=%0d", a, j),
                   int'(refresh_gl), ((j % PER) < P) ? 1 : 0);
            end
            if (which == 0) stage_en = 1'b0; else supply_ok = 1'b0;
            #1;
            chk($sformatf("%s gate at abort a=%0d", tag, a), int'(refresh_gl), 0);
            chk($sformatf("%s override at abort a=%0d", tag, a), int'(override_active), 0);
            @(negedge clk);
            stage_en = 1'b1; supply_ok = 1'b1;
            #1 chk($sformatf("%s state cleared a=%0d", tag, a), int'(override_active), 0);
            @(negedge clk);
            chk($sformatf("%s stays idle a=%0d", tag, a), int'(refresh_gl), 0);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule